// File: doc/BRIEF.md
# Multi-mode 8b/10b Comma Aligner

This block finds character boundaries in a received 8b/10b stream. Each accepted input beat carries ten raw bits in arrival order, with `in_data[0]` received first. The block joins that beat with the previous one into a 20-bit window. It tests all ten bit offsets against a framing pattern, then emits one 10-bit character cut from the window at the offset it has chosen. Two static selects set the behaviour. One picks the pattern: the full K28.5 character, or only its 7-bit comma. The other picks when the boundary may move: on every detection, after a confirmed pair, or after a run of four hits.

Data moves through a one-deep output register with a valid/ready handshake. A beat is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being read in the same cycle. While `out_valid` is high and `out_ready` is low, the output character, offset and valid are held. When the beat is accepted, the character, the offset and the realign pulse all appear one clock later. The selects should change only while the block is in reset.

Top module: `comma_align`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0, `realign` is 0 and `cur_offset` is 0.
- R2: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `cur_offset` hold their values.
- R3: With `pat_sel` = 2'b10, a detection is a 10-bit window slice equal to K28.5 in either disparity. In arrival order the two forms are 0011111010 and 1100000101.
- R4: With `pat_sel` = 2'b01, a detection is a slice whose first seven arrival bits are 0011111 or 1100000.
- R5: With `pat_sel` = 2'b00 or 2'b11, nothing is detected: `cur_offset` stays 0 and `realign` never rises.
- R6: Window bit j is bit j of the previous accepted beat for j < 10, and bit j-10 of the current beat otherwise. Offset k selects window bits k to k+9. The lowest matching offset wins. Each accepted beat produces `out_data` = window slice at the offset in force after that beat.
- R7: With `pol_sel` = 2'b00 (immediate; 2'b11 behaves the same), a detection at an offset other than the current one moves the offset at once. The output beat for that input has `out_valid` low.
- R8: With `pol_sel` = 2'b01 (pair), the offset moves to k when a detection at k follows an earlier detection at k by 1 to 4 accepted beats.
- R9: In pair mode, a detection at a different offset, or one more than 4 beats after the pending one, becomes the new pending detection. A confirmation clears the pending detection.
- R10: With `pol_sel` = 2'b10 (quad), the offset moves to k after detections at k on four consecutive accepted beats. A beat with no detection, or with a detection at another offset, restarts the run. A confirmation ends the run.
- R11: In pair and quad modes, every accepted beat yields `out_valid` high, including the beat that moves the offset.
- R12: `realign` is high for exactly the cycle in which `cur_offset` takes a new, different value, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pat_sel | input | 2 | Framing pattern select (static) |
| pol_sel | input | 2 | Reframe policy select (static) |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can accept a beat |
| in_data | input | 10 | Raw bits, bit 0 received first |
| out_valid | output | 1 | Aligned character valid |
| out_ready | input | 1 | Downstream accepts the character |
| out_data | output | 10 | Aligned character, bit 0 first |
| cur_offset | output | 4 | Bit offset in force (0 to 9) |
| realign | output | 1 | One-cycle pulse on an offset change |

## Verification
The stimulus is a filler stream of alternating bits with bursts of framing characters in both disparities. Each burst sits at a random bit phase, with a random spacing between characters. Spacings of one character confirm quad runs, and spacings from two to six characters fall on both sides of the pair window, so the two confirm modes are told apart. Random phase changes between bursts exercise restarts. Each policy runs with both pattern selects, and the reserved selects are run to show that nothing is detected. Random gaps on `in_valid` and random back-pressure on `out_ready` show that the window, counts and outputs advance only on accepted beats.

// File: rtl/ca_pkg.sv
package ca_pkg;
  localparam int CHAR_W = 10;
  localparam int COMMA_W = 7;

  localparam logic [1:0] PAT_COMMA = 2'b01;
  localparam logic [1:0] PAT_FULL  = 2'b10;

  typedef enum logic [1:0] {
    POL_IMM  = 2'b00,
    POL_PAIR = 2'b01,
    POL_QUAD = 2'b10,
    POL_RSV  = 2'b11
  } pol_e;

  // patterns stored with bit 0 = first bit received
  localparam logic [CHAR_W-1:0]  K_RDN = 10'b0101111100;
  localparam logic [CHAR_W-1:0]  K_RDP = 10'b1010000011;
  localparam logic [COMMA_W-1:0] C_RDN = 7'b1111100;
  localparam logic [COMMA_W-1:0] C_RDP = 7'b0000011;
endpackage

// File: rtl/ca_scan.sv
module ca_scan #(
  parameter int W = 10
) (
  input  logic [2*W-1:0]         win,
  input  logic [1:0]             pat_sel,
  output logic                   hit,
  output logic [$clog2(W)-1:0]   hit_off
);
  import ca_pkg::*;
  localparam int OW = $clog2(W);

  logic use_full, use_comma;
  logic [W-1:0] match;

  assign use_full  = (pat_sel == PAT_FULL);
  assign use_comma = (pat_sel == PAT_COMMA);

  for (genvar k = 0; k < W; k++) begin : g_off
    logic [W-1:0] slice;
    assign slice = win[k +: W];
    assign match[k] = (use_full  && (slice == K_RDN || slice == K_RDP)) ||
                      (use_comma && (slice[COMMA_W-1:0] == C_RDN ||
                                     slice[COMMA_W-1:0] == C_RDP));
  end

  always_comb begin
    hit = |match;
    hit_off = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (match[k]) hit_off = OW'(k);
    end
  end

  always_comb begin
    if (!(use_full || use_comma)) a_r5_no_match_reserved: assert (match == '0);
  end
endmodule

// File: rtl/ca_policy.sv
module ca_policy #(
  parameter int W = 10,
  parameter int PAIR_SPAN = 5,
  parameter int QUAD_RUN = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  input  logic [1:0]           pol_sel,
  input  logic                 hit,
  input  logic [$clog2(W)-1:0] hit_off,
  output logic [$clog2(W)-1:0] off_q,
  output logic [$clog2(W)-1:0] eff_off,
  output logic                 chg,
  output logic                 drop
);
  import ca_pkg::*;
  localparam int OW = $clog2(W);
  localparam int AW = $clog2(PAIR_SPAN);
  localparam int HW = $clog2(QUAD_RUN + 1);
  localparam logic [AW-1:0] AGE_LAST = AW'(PAIR_SPAN - 2);
  localparam logic [HW-1:0] RUN_LAST = HW'(QUAD_RUN - 1);

  pol_e pol;
  assign pol = pol_e'(pol_sel);

  logic          cand_v, cand_v_n;
  logic [OW-1:0] cand_off, cand_off_n;
  logic [AW-1:0] age, age_n;
  logic [HW-1:0] run, run_n;
  logic          confirm;

  always_comb begin
    cand_v_n   = cand_v;
    cand_off_n = cand_off;
    age_n      = age;
    run_n      = run;
    confirm    = 1'b0;
    eff_off    = off_q;
    drop       = 1'b0;
    if (step) begin
      unique case (pol)
        POL_PAIR: begin
          if (hit) begin
            if (cand_v && hit_off == cand_off) begin
              confirm  = 1'b1;
              cand_v_n = 1'b0;
            end else begin
              cand_v_n   = 1'b1;
              cand_off_n = hit_off;
              age_n      = '0;
            end
          end else if (cand_v) begin
            if (age == AGE_LAST) cand_v_n = 1'b0;
            else                 age_n = age + 1'b1;
          end
        end
        POL_QUAD: begin
          if (hit) begin
            if (cand_v && hit_off == cand_off) begin
              if (run == RUN_LAST) begin
                confirm  = 1'b1;
                cand_v_n = 1'b0;
                run_n    = '0;
              end else begin
                run_n = run + 1'b1;
              end
            end else begin
              cand_v_n   = 1'b1;
              cand_off_n = hit_off;
              run_n      = HW'(1);
            end
          end else begin
            cand_v_n = 1'b0;
            run_n    = '0;
          end
        end
        default: begin
          if (hit && hit_off != off_q) begin
            eff_off = hit_off;
            drop    = 1'b1;
          end
        end
      endcase
      if (confirm) eff_off = cand_off;
    end
    chg = step && (eff_off != off_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q    <= '0;
      cand_v   <= 1'b0;
      cand_off <= '0;
      age      <= '0;
      run      <= '0;
    end else if (step) begin
      off_q    <= eff_off;
      cand_v   <= cand_v_n;
      cand_off <= cand_off_n;
      age      <= age_n;
      run      <= run_n;
    end
  end

  a_r6_offset_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    off_q < OW'(W));
  a_r9_pair_age_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (pol == POL_PAIR && cand_v) |-> age <= AGE_LAST);
  a_r10_quad_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (pol == POL_QUAD) |-> run <= RUN_LAST);
endmodule

// File: rtl/ca_select.sv
module ca_select #(
  parameter int W = 10
) (
  input  logic [2*W-1:0]       win,
  input  logic [$clog2(W)-1:0] off,
  output logic [W-1:0]         chr
);
  logic [2*W-1:0] shifted;
  assign shifted = win >> off;
  assign chr = shifted[W-1:0];
endmodule

// File: rtl/comma_align.sv
module comma_align #(
  parameter int W = 10,
  parameter int PAIR_SPAN = 5,
  parameter int QUAD_RUN = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           pat_sel,
  input  logic [1:0]           pol_sel,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [W-1:0]         in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [W-1:0]         out_data,
  output logic [$clog2(W)-1:0] cur_offset,
  output logic                 realign
);
  import ca_pkg::*;
  localparam int OW = $clog2(W);

  logic [W-1:0]   prev_q;
  logic [2*W-1:0] win;
  logic           accept;
  logic           hit, chg, drop;
  logic [OW-1:0]  hit_off, eff_off;
  logic [W-1:0]   chr;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign win      = {in_data, prev_q};

  ca_scan #(.W(W)) u_scan (
    .win(win), .pat_sel(pat_sel), .hit(hit), .hit_off(hit_off)
  );

  ca_policy #(.W(W), .PAIR_SPAN(PAIR_SPAN), .QUAD_RUN(QUAD_RUN)) u_policy (
    .clk(clk), .rst_n(rst_n), .step(accept), .pol_sel(pol_sel),
    .hit(hit), .hit_off(hit_off), .off_q(cur_offset),
    .eff_off(eff_off), .chg(chg), .drop(drop)
  );

  ca_select #(.W(W)) u_sel (.win(win), .off(eff_off), .chr(chr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
      realign   <= 1'b0;
    end else begin
      realign <= chg;
      if (accept) begin
        prev_q    <= in_data;
        out_data  <= chr;
        out_valid <= !drop;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  a_r2_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(cur_offset)));
  a_r12_pulse_means_change: assert property (@(posedge clk) disable iff (!rst_n)
    realign |-> cur_offset != $past(cur_offset));
  a_r12_no_pulse_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !realign |-> $stable(cur_offset));
  a_r11_confirm_keeps_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (pol_sel == POL_PAIR || pol_sel == POL_QUAD)) |=> out_valid);
  a_r7_immediate_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (realign && (pol_sel == POL_IMM || pol_sel == POL_RSV)) |-> !out_valid);
  a_r5_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_sel == 2'b00 || pat_sel == 2'b11) |-> !realign);
endmodule

// File: tb/sim_comma_align.sv
module sim_comma_align;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pat_sel = 2'b10, pol_sel = 2'b00;
  logic       in_valid = 1'b0, out_ready = 1'b0;
  logic [9:0] in_data = '0;
  logic       in_ready, out_valid, realign;
  logic [9:0] out_data;
  logic [3:0] cur_offset;

  always #10 clk = ~clk;

  comma_align u0 (
    .clk(clk), .rst_n(rst_n), .pat_sel(pat_sel), .pol_sel(pol_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .cur_offset(cur_offset), .realign(realign)
  );

  int tests = 0, fails = 0;
  int kchar[10] = '{0,0,1,1,1,1,1,0,1,0};

  // reference state
  bit   bits[$];
  bit   fb;
  logic [9:0] m_prev, m_od;
  int   m_off;
  bit   m_ov, m_re;
  int   beat, pend_off, pend_beat, run_off, run_len;
  string ptag, otag, vtag;

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_prev = '0; m_od = '0; m_off = 0; m_ov = 0; m_re = 0;
    beat = 0; pend_off = -1; pend_beat = 0; run_off = -1; run_len = 0;
  endtask

  function automatic bit wbit(input logic [9:0] pv, input logic [9:0] cu, input int j);
    return (j < 10) ? pv[j] : cu[j-10];
  endfunction

  function automatic int find_hit(input logic [9:0] pv, input logic [9:0] cu);
    for (int k = 0; k < 10; k++) begin
      int len = (pat_sel == 2'b10) ? 10 : 7;
      bit eq_a = 1, eq_b = 1;
      if (pat_sel != 2'b10 && pat_sel != 2'b01) return -1;
      for (int i = 0; i < len; i++) begin
        if (wbit(pv, cu, k+i) != kchar[i][0]) eq_a = 0;
        if (wbit(pv, cu, k+i) == kchar[i][0]) eq_b = 0;
      end
      if (eq_a || eq_b) return k;
    end
    return -1;
  endfunction

  task automatic model_step(input bit acc, input logic [9:0] d);
    int h, noff;
    if (!acc) begin
      m_re = 0;
      if (out_ready) m_ov = 0;
      return;
    end
    h = find_hit(m_prev, d);
    noff = m_off;
    beat++;
    if (pol_sel == 2'b01) begin
      if (h >= 0) begin
        if (pend_off == h && beat - pend_beat <= 4) begin noff = h; pend_off = -1; end
        else begin pend_off = h; pend_beat = beat; end
      end
    end else if (pol_sel == 2'b10) begin
      if (h >= 0) begin
        if (h == run_off && run_len > 0) run_len++;
        else begin run_off = h; run_len = 1; end
        if (run_len == 4) begin noff = h; run_len = 0; run_off = -1; end
      end else begin run_len = 0; run_off = -1; end
    end else if (h >= 0) begin
      noff = h;
    end
    m_re = (noff != m_off);
    m_ov = !((pol_sel == 2'b00 || pol_sel == 2'b11) && m_re);
    for (int i = 0; i < 10; i++) m_od[i] = wbit(m_prev, d, noff + i);
    m_off = noff;
    m_prev = d;
  endtask

  task automatic push_fill(input int n);
    for (int i = 0; i < n; i++) begin bits.push_back(fb); fb = ~fb; end
  endtask

  task automatic build_stream();
    bits.delete();
    fb = 1;
    while (bits.size() < 3000) begin
      int n = $urandom_range(1, 6);
      int s = $urandom_range(1, 6);
      push_fill($urandom_range(0, 9));
      for (int c = 0; c < n; c++) begin
        bit inv = $urandom_range(0, 1);
        for (int i = 0; i < 10; i++) bits.push_back(kchar[i][0] ^ inv);
        push_fill((s - 1) * 10);
      end
      if ($urandom_range(0, 3) == 0)
        for (int i = 0; i < 10; i++) bits.push_back($urandom_range(0, 1));
    end
  endtask

  task automatic run_cfg(input logic [1:0] p, input logic [1:0] o);
    @(negedge clk);
    rst_n = 0; in_valid = 0; out_ready = 0; pat_sel = p; pol_sel = o;
    ptag = (p == 2'b10) ? "R3" : (p == 2'b01) ? "R4" : "R5";
    otag = (o == 2'b01) ? "R8 R9" : (o == 2'b10) ? "R10" : "R7";
    vtag = (o == 2'b00) ? "R7" : "R11";
    model_reset();
    @(negedge clk);
    chk("R1 out_valid in reset", out_valid, 0);
    chk("R1 realign in reset", realign, 0);
    chk("R1 offset in reset", cur_offset, 0);
    rst_n = 1;
    build_stream();
    while (bits.size() >= 10) begin
      logic [9:0] d;
      bit acc;
      in_valid = ($urandom_range(0, 9) < 8);
      out_ready = ($urandom_range(0, 3) != 0);
      for (int i = 0; i < 10; i++) d[i] = bits[i];
      in_data = in_valid ? d : 10'($urandom_range(0, 1023));
      #1;
      chk("R2 in_ready", in_ready, int'(!m_ov || out_ready));
      acc = in_valid && (!m_ov || out_ready);
      if (acc) repeat (10) void'(bits.pop_front());
      model_step(acc, d);
      @(negedge clk);
      chk({vtag, " out_valid"}, out_valid, m_ov);
      chk({ptag, " ", otag, " offset"}, cur_offset, m_off);
      chk("R12 realign", realign, m_re);
      if (m_ov) chk("R6 out_data", out_data, m_od);
    end
    if (p != 2'b10 && p != 2'b01) chk("R5 offset after stream", cur_offset, 0);
  endtask

  initial begin
    run_cfg(2'b10, 2'b00);
    run_cfg(2'b01, 2'b00);
    run_cfg(2'b10, 2'b01);
    run_cfg(2'b01, 2'b01);
    run_cfg(2'b10, 2'b10);
    run_cfg(2'b01, 2'b10);
    run_cfg(2'b00, 2'b01);
    run_cfg(2'b11, 2'b00);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule